// File: doc/BRIEF.md
# Write-Back Write-Allocate Cache Miss Controller

This block is the control and state part of a direct-mapped cache that writes back and allocates on writes. It sits between a processor request port and a memory system that has two channels: a line-fill read channel and a writeback channel. Both channels move one 32-bit word per granted beat. Loads and stores that hit finish in one cycle. A store that hits changes only the cached copy and marks the line modified.

On a miss, the controller first looks at the line that already occupies the indexed entry. If that victim line is modified, the controller copies it into an eviction buffer, which drains it to memory on its own. The controller then fetches the target line in four sequential beats and overwrites the entry. Only after that does it apply the pending store, or return the requested word for a load. Because the eviction buffer drains on its own, the processor can finish the miss and keep hitting while the writeback is still in flight. Two kinds of later miss must wait for the buffer to empty: one whose own victim is modified, and one whose target line is the line still being drained.

Top module: `wbwa_miss_ctrl`

## Requirements
- R1: Reset clears every valid and modified flag. While reset is held, `cpu_busy`, `cpu_done`, `rd_req` and `wb_req` are 0. The first access to any address after reset is a miss.
- R2: A request accepted while `cpu_busy` is 0 that hits completes with `cpu_done` high in the next cycle, and `cpu_busy` stays 0. For a load, `cpu_rdata` in that cycle holds the cached word.
- R3: A store that hits updates only the cached word and marks the line modified. Memory is not written until that line is evicted.
- R4: After a miss is detected, `cpu_busy` is 1 from the next cycle until the access completes. `cpu_done` is 1 in the cycle in which `cpu_busy` falls. With an idle memory, a clean-victim miss takes 7 cycles from the request cycle to `cpu_done`.
- R5: A miss fetches the target line as four beats on the read channel, at line base + 0, 4, 8, 12 in that order. The pending store is applied after the fill (write allocate). The other words of the line come from memory.
- R6: A modified victim is written back as four beats on the writeback channel, at its own line base + 0, 4, 8, 12. Address and data are held until each beat is granted. A clean victim produces no writeback beats.
- R7: A fill caused by a load leaves the line unmodified. A fill caused by a store leaves it modified.
- R8: The processor completes a miss, and goes on with hits and clean-victim misses to other lines, while the eviction buffer is still draining.
- R9: A miss whose victim is modified waits, with `rd_req` at 0, while the eviction buffer holds an earlier line. It continues once that line has drained.
- R10: A miss whose target line is the one in the eviction buffer does not read memory until the drain ends. It then returns the written-back data.
- R11: Address fields: bits 15:10 are the tag, bits 9:4 the line index, bits 3:2 the word within the line, and bits 3:0 the byte offset. Addresses that differ only in the tag conflict in one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_busy` is 0 |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Miss in progress; no new request accepted |
| rd_req | output | 1 | Fill read beat request |
| rd_addr | output | 16 | Fill beat byte address |
| rd_gnt | input | 1 | Fill beat granted; `rd_data` is valid in the same cycle |
| rd_data | input | 32 | Fill beat data |
| wb_req | output | 1 | Writeback beat request |
| wb_addr | output | 16 | Writeback beat byte address |
| wb_data | output | 32 | Writeback beat data |
| wb_gnt | input | 1 | Writeback beat accepted |

## Verification
The hardest cases to reach are the two waits on the eviction buffer. Each needs a modified line to be evicted, and then a second miss while that line is still in the buffer: either a miss whose victim is also modified, or a miss that wants the very line being drained. With a free-running memory the drain ends well within the next miss, so the overlap never happens. The stimulus therefore holds the writeback grant low and builds the overlap on purpose. It dirties a line, evicts it with a conflicting load, then asks again for the evicted line or misses on a second modified entry. While the grant stays low, the bench checks that the processor side is stalled and no fill read has gone out. It then releases the grant and checks that the returned data is the written-back data.

// File: rtl/wbwa_pkg.sv
package wbwa_pkg;
  parameter int ADDR_W = 16;
  parameter int WORD_W = 32;
  parameter int LINES  = 64;
  parameter int BEATS  = 4;

  localparam int BEAT_W = $clog2(BEATS);
  localparam int OFF_W  = BEAT_W + 2;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = TAG_W + IDX_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [BEATS-1:0][WORD_W-1:0] line_data_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_FETCH, ST_COMPLETE} miss_state_t;

  function automatic tag_t tag_of(addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic idx_t index_of(addr_t a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic beat_t word_of(addr_t a);
    return a[2 +: BEAT_W];
  endfunction

  function automatic line_t line_of(addr_t a);
    return a[OFF_W +: LINE_W];
  endfunction

  function automatic addr_t beat_addr(line_t ln, beat_t b);
    return {ln, b, 2'b00};
  endfunction
endpackage

// File: rtl/wbwa_tag_store.sv
module wbwa_tag_store import wbwa_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  idx_t look_idx,
  output logic look_valid,
  output logic look_dirty,
  output tag_t look_tag,
  input  logic mark_en,
  input  idx_t mark_idx,
  input  logic fill_en,
  input  idx_t fill_idx,
  input  tag_t fill_tag,
  input  logic fill_dirty
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  tag_t             tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= fill_dirty;
    end else if (mark_en) begin
      dirty_q[mark_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign look_valid = valid_q[look_idx];
  assign look_dirty = dirty_q[look_idx];
  assign look_tag   = tag_q[look_idx];
endmodule

// File: rtl/wbwa_data_store.sv
module wbwa_data_store import wbwa_pkg::*; (
  input  logic       clk,
  input  logic       wr_en,
  input  idx_t       wr_idx,
  input  beat_t      wr_word,
  input  word_t      wr_data,
  input  idx_t       rd_idx,
  output line_data_t rd_line
);
  line_data_t lines_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) lines_q[wr_idx][wr_word] <= wr_data;
  end

  assign rd_line = lines_q[rd_idx];
endmodule

// File: rtl/wbwa_evict_buf.sv
module wbwa_evict_buf import wbwa_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  line_t      load_line,
  input  line_data_t load_words,
  output logic       busy,
  output line_t      line_q,
  output logic       wb_req,
  output addr_t      wb_addr,
  output word_t      wb_data,
  input  logic       wb_gnt
);
  line_data_t words_q;
  beat_t      beat_q;
  logic       busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      line_q  <= '0;
      words_q <= '0;
    end else if (load && !busy_q) begin
      line_q  <= load_line;
      words_q <= load_words;
      beat_q  <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q && wb_gnt) begin
      beat_q <= beat_q + 1'b1;
      if (beat_q == beat_t'(BEATS-1)) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign wb_req  = busy_q;
  assign wb_addr = beat_addr(line_q, beat_q);
  assign wb_data = words_q[beat_q];
endmodule

// File: rtl/wbwa_miss_ctrl.sv
module wbwa_miss_ctrl import wbwa_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0]   cpu_wdata,
  output logic [WORD_W-1:0]   cpu_rdata,
  output logic                cpu_done,
  output logic                cpu_busy,
  output logic                rd_req,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_gnt,
  input  logic [WORD_W-1:0]   rd_data,
  output logic                wb_req,
  output logic [ADDR_W-1:0]   wb_addr,
  output logic [WORD_W-1:0]   wb_data,
  input  logic                wb_gnt
);
  miss_state_t state_q;
  logic        req_we_q;
  addr_t       req_addr_q;
  word_t       req_wdata_q;
  beat_t       beat_q;
  word_t       rdata_q;
  logic        done_q;

  // Named events used by the design and by the bound checker
  addr_t      look_addr;
  logic       look_valid, look_dirty;
  tag_t       look_tag;
  line_data_t line_words;
  logic       hit_w, hit_acc, miss_det;
  logic       victim_dirty, evb_load, check_go;
  logic       evb_busy, line_clash, fill_beat, fill_last, complete;
  line_t      evb_line, rd_line;
  logic       dwr_en;
  idx_t       dwr_idx;
  beat_t      dwr_word;
  word_t      dwr_data;
  logic       unused_addr_bits;

  assign look_addr = (state_q == ST_IDLE) ? cpu_addr : req_addr_q;
  assign hit_w     = look_valid && (look_tag == tag_of(look_addr));
  assign hit_acc   = (state_q == ST_IDLE) && cpu_req && hit_w;
  assign miss_det  = (state_q == ST_IDLE) && cpu_req && !hit_w;

  assign victim_dirty = look_valid && look_dirty;
  assign evb_load     = (state_q == ST_CHECK) && victim_dirty && !evb_busy;
  assign check_go     = (state_q == ST_CHECK) && (!victim_dirty || !evb_busy);

  assign rd_line    = line_of(req_addr_q);
  assign line_clash = evb_busy && (evb_line == rd_line);
  assign rd_req     = (state_q == ST_FETCH) && !line_clash;
  assign rd_addr    = beat_addr(rd_line, beat_q);
  assign fill_beat  = rd_req && rd_gnt;
  assign fill_last  = (beat_q == beat_t'(BEATS-1));
  assign complete   = (state_q == ST_COMPLETE);

  assign unused_addr_bits = ^{cpu_addr[1:0], req_addr_q[1:0]};

  always_comb begin
    dwr_en   = 1'b0;
    dwr_idx  = index_of(req_addr_q);
    dwr_word = word_of(req_addr_q);
    dwr_data = req_wdata_q;
    if (hit_acc && cpu_we) begin
      dwr_en   = 1'b1;
      dwr_idx  = index_of(cpu_addr);
      dwr_word = word_of(cpu_addr);
      dwr_data = cpu_wdata;
    end else if (fill_beat) begin
      dwr_en   = 1'b1;
      dwr_word = beat_q;
      dwr_data = rd_data;
    end else if (complete && req_we_q) begin
      dwr_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      beat_q      <= '0;
      rdata_q     <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= hit_acc || complete;
      case (state_q)
        ST_IDLE: begin
          if (hit_acc && !cpu_we) rdata_q <= line_words[word_of(cpu_addr)];
          if (miss_det) begin
            req_we_q    <= cpu_we;
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
            state_q     <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (check_go) begin
            beat_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fill_beat) begin
            beat_q <= beat_q + 1'b1;
            if (fill_last) state_q <= ST_COMPLETE;
          end
        end
        ST_COMPLETE: begin
          if (!req_we_q) rdata_q <= line_words[word_of(req_addr_q)];
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rdata = rdata_q;
  assign cpu_done  = done_q;
  assign cpu_busy  = (state_q != ST_IDLE);

  wbwa_tag_store i_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_idx   (index_of(look_addr)),
    .look_valid (look_valid),
    .look_dirty (look_dirty),
    .look_tag   (look_tag),
    .mark_en    (hit_acc && cpu_we),
    .mark_idx   (index_of(cpu_addr)),
    .fill_en    (complete),
    .fill_idx   (index_of(req_addr_q)),
    .fill_tag   (tag_of(req_addr_q)),
    .fill_dirty (req_we_q)
  );

  wbwa_data_store i_data (
    .clk     (clk),
    .wr_en   (dwr_en),
    .wr_idx  (dwr_idx),
    .wr_word (dwr_word),
    .wr_data (dwr_data),
    .rd_idx  (index_of(look_addr)),
    .rd_line (line_words)
  );

  wbwa_evict_buf i_evb (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (evb_load),
    .load_line  ({look_tag, index_of(req_addr_q)}),
    .load_words (line_words),
    .busy       (evb_busy),
    .line_q     (evb_line),
    .wb_req     (wb_req),
    .wb_addr    (wb_addr),
    .wb_data    (wb_data),
    .wb_gnt     (wb_gnt)
  );
endmodule

// File: rtl/wbwa_miss_chk.sv
module wbwa_miss_chk import wbwa_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_busy,
  input logic              cpu_done,
  input logic              rd_req,
  input logic              rd_gnt,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wb_req,
  input logic              wb_gnt,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [WORD_W-1:0] wb_data,
  input logic              hit_acc,
  input logic              miss_det,
  input logic              evb_load,
  input logic              evb_busy
);
  // R2
  hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_acc |=> cpu_done && !cpu_busy);

  // R4
  miss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_det |=> cpu_busy && !cpu_done);

  // R4
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_busy) |-> cpu_done);

  // R9
  evb_free_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evb_load |-> !evb_busy);

  // R10
  fill_not_draining_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && wb_req |-> rd_addr[ADDR_W-1:OFF_W] != wb_addr[ADDR_W-1:OFF_W]);

  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_gnt |=> wb_req && $stable(wb_addr) && $stable(wb_data));

  // R5
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr));

  // R5
  fill_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> cpu_busy);
endmodule

bind wbwa_miss_ctrl wbwa_miss_chk i_wbwa_miss_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_busy (cpu_busy),
  .cpu_done (cpu_done),
  .rd_req   (rd_req),
  .rd_gnt   (rd_gnt),
  .rd_addr  (rd_addr),
  .wb_req   (wb_req),
  .wb_gnt   (wb_gnt),
  .wb_addr  (wb_addr),
  .wb_data  (wb_data),
  .hit_acc  (hit_acc),
  .miss_det (miss_det),
  .evb_load (evb_load),
  .evb_busy (evb_busy)
);

// File: tb/test_wbwa_miss_ctrl.sv
module test_wbwa_miss_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_done, cpu_busy;
  logic        rd_req, rd_gnt, wb_req, wb_gnt;
  logic [15:0] rd_addr, wb_addr;
  logic [31:0] rd_data, wb_data;
  logic        rd_stall = 1'b0, wb_stall = 1'b0, mem_fill = 1'b1;

  logic [31:0] mem [1024];
  logic [15:0] rd_log [4];
  logic [15:0] wb_log [4];
  int rd_n = 0, wb_n = 0;
  int checks = 0, failures = 0;

  always #2ns clk = ~clk;

  assign rd_gnt  = !rd_stall;
  assign wb_gnt  = !wb_stall;
  assign rd_data = mem[rd_addr[11:2]];

  always @(posedge clk) begin
    if (mem_fill) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hC0DE0000 + i;
    end else if (wb_req && wb_gnt) begin
      mem[wb_addr[11:2]] <= wb_data;
    end
  end

  always @(posedge clk) begin
    if (rd_req && rd_gnt) begin
      rd_log[rd_n[1:0]] <= rd_addr;
      rd_n <= rd_n + 1;
    end
    if (wb_req && wb_gnt) begin
      wb_log[wb_n[1:0]] <= wb_addr;
      wb_n <= wb_n + 1;
    end
  end

  wbwa_miss_ctrl i_wbwa_miss_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_data(rd_data),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_gnt(wb_gnt)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic        hit;
    logic [31:0] data;
    logic [2:0]  wb;
  } vec_t;

  // Memory starts as C0DE0000 + word index. Tag bits 15:10, index bits 9:4.
  localparam vec_t VECS [12] = '{
    '{1'b0, 16'h0004, 32'h0,        1'b0, 32'hC0DE0001, 3'd0},
    '{1'b0, 16'h0008, 32'h0,        1'b1, 32'hC0DE0002, 3'd0},
    '{1'b1, 16'h000C, 32'h11111111, 1'b1, 32'h0,        3'd0},
    '{1'b0, 16'h000C, 32'h0,        1'b1, 32'h11111111, 3'd0},
    '{1'b1, 16'h0414, 32'h22222222, 1'b0, 32'h0,        3'd0},
    '{1'b0, 16'h0410, 32'h0,        1'b1, 32'hC0DE0104, 3'd0},
    '{1'b0, 16'h0414, 32'h0,        1'b1, 32'h22222222, 3'd0},
    '{1'b0, 16'h0400, 32'h0,        1'b0, 32'hC0DE0100, 3'd4},
    '{1'b0, 16'h000C, 32'h0,        1'b0, 32'h11111111, 3'd0},
    '{1'b1, 16'h0810, 32'h33333333, 1'b0, 32'h0,        3'd4},
    '{1'b0, 16'h0414, 32'h0,        1'b0, 32'h22222222, 3'd4},
    '{1'b0, 16'h0810, 32'h0,        1'b0, 32'h33333333, 3'd0}
  };

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!cpu_done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    if (!cpu_done) chk("R4 completion timeout", 1'b0, 32'(lat), 32'd0);
  endtask

  task automatic drain();
    int n = 0;
    while (wb_req && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] rdata, output bit hit, output bit busy1, output int lat);
    issue(we, a, d);
    hit   = cpu_done;
    busy1 = cpu_busy;
    wait_done(lat);
    rdata = cpu_rdata;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit hit, busy1;
    int lat, w0;

    // R1: reset state
    repeat (2) @(negedge clk);
    mem_fill = 1'b0;
    chk("R1 reset outputs", {cpu_busy, cpu_done, rd_req, wb_req} == 4'b0,
        32'({cpu_busy, cpu_done, rd_req, wb_req}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {cpu_busy, cpu_done} == 2'b0, 32'({cpu_busy, cpu_done}), 32'd0);

    // Vector walk: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < 12; i++) begin
      w0 = wb_n;
      access(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, hit, busy1, lat);
      drain();
      chk("R2/R4 hit or miss", hit == VECS[i].hit, 32'(hit), 32'(VECS[i].hit));
      if (VECS[i].hit) chk("R2 no busy on hit", !busy1, 32'(busy1), 32'd0);
      else begin
        chk("R4 busy after miss", busy1, 32'(busy1), 32'd1);
        chk("R4 miss latency", lat == 7, 32'(lat), 32'd7);
      end
      if (!VECS[i].we) chk("R5 R7 read data", rd == VECS[i].data, rd, VECS[i].data);
      chk("R6 R7 writeback beats", (wb_n - w0) == int'(VECS[i].wb), 32'(wb_n - w0), 32'(VECS[i].wb));
      if (i == 0)
        chk("R5 R11 fill beat order", rd_log[0] == 16'h0 && rd_log[1] == 16'h4 &&
            rd_log[2] == 16'h8 && rd_log[3] == 16'hC, 32'(rd_log[3]), 32'hC);
      if (i == 2) chk("R3 memory untouched by hit store", mem[3] == 32'hC0DE0003, mem[3], 32'hC0DE0003);
      if (i == 7) begin
        chk("R6 R11 writeback beat order", wb_log[0] == 16'h0 && wb_log[1] == 16'h4 &&
            wb_log[2] == 16'h8 && wb_log[3] == 16'hC, 32'(wb_log[3]), 32'hC);
        chk("R11 conflicting tag fill", rd_log[0] == 16'h400 && rd_log[3] == 16'h40C,
            32'(rd_log[3]), 32'h40C);
        chk("R6 written-back word", mem[3] == 32'h11111111, mem[3], 32'h11111111);
      end
    end

    // R8 and R10: drain stalled, then ask for the line being drained
    wb_stall = 1'b1;
    access(1'b1, 16'h0020, 32'hAAAA0001, rd, hit, busy1, lat);
    access(1'b0, 16'h0420, 32'h0, rd, hit, busy1, lat);
    chk("R8 miss completes during drain", lat == 7, 32'(lat), 32'd7);
    chk("R8 drain still pending", wb_req, 32'(wb_req), 32'd1);
    access(1'b0, 16'h0424, 32'h0, rd, hit, busy1, lat);
    chk("R8 hit during drain", hit, 32'(hit), 32'd1);
    chk("R8 hit data during drain", rd == 32'hC0DE0109, rd, 32'hC0DE0109);
    issue(1'b0, 16'h0020, 32'h0);
    repeat (20) @(negedge clk);
    chk("R10 waits on evicted line", cpu_busy && !rd_req, 32'({cpu_busy, rd_req}), 32'h2);
    wb_stall = 1'b0;
    wait_done(lat);
    chk("R10 returns written-back data", cpu_rdata == 32'hAAAA0001, cpu_rdata, 32'hAAAA0001);
    drain();
    chk("R6 drained line in memory", mem[8] == 32'hAAAA0001, mem[8], 32'hAAAA0001);

    // R9: dirty victim while the buffer is still occupied
    wb_stall = 1'b1;
    access(1'b1, 16'h0040, 32'hB1B1B1B1, rd, hit, busy1, lat);
    access(1'b0, 16'h0440, 32'h0, rd, hit, busy1, lat);
    access(1'b1, 16'h0050, 32'hB2B2B2B2, rd, hit, busy1, lat);
    chk("R8 clean miss runs beside drain", lat == 7, 32'(lat), 32'd7);
    issue(1'b0, 16'h0450, 32'h0);
    repeat (20) @(negedge clk);
    chk("R9 dirty victim waits for buffer", cpu_busy && !rd_req && wb_req,
        32'({cpu_busy, rd_req, wb_req}), 32'h5);
    wb_stall = 1'b0;
    wait_done(lat);
    chk("R9 data after wait", cpu_rdata == 32'hC0DE0114, cpu_rdata, 32'hC0DE0114);
    drain();
    chk("R6 first buffered line", mem[16] == 32'hB1B1B1B1, mem[16], 32'hB1B1B1B1);
    chk("R6 second buffered line", mem[20] == 32'hB2B2B2B2, mem[20], 32'hB2B2B2B2);

    // R1: reset drops every valid line
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 16'h000C, 32'h0, rd, hit, busy1, lat);
    chk("R1 miss after reset", !hit, 32'(hit), 32'd0);
    chk("R1 data after reset", rd == 32'h11111111, rd, 32'h11111111);

    summary();
    $finish;
  end
endmodule